// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block decides whether a processor core should be given a hard interrupt request and which trap type goes with it. It merges sixteen external level lines with a software interrupt register. That register also carries two timer-match flags, and both flags are treated as level 14. The block then finds the highest pending level that lies strictly above the core's current priority threshold. The chosen level is turned into a trap type in the external-interrupt group (base 0x40 ORed with the level number). The request and trap type are held in registers and are re-evaluated on every clock edge.

Two conditions can keep the outputs where they are. The first is a pending vector interrupt, which outranks every external level. The second is an external-level trap that is already being serviced at a higher trap type. Disabling interrupts withdraws any outstanding request, and so does a threshold that leaves nothing pending above it.

Top module: `irq_level_resolver`

## Requirements
- R1: During reset, and whenever no request is outstanding, `irq_req_o` is 0 and `irq_tt_o` is 0.
- R2: The pending vector is the external lines ORed with bits 15..1 of `soft_int_i`. Bit 0 (tick match) and bit 16 (system-tick match) of `soft_int_i` never show up as level 0 or as a level of their own.
- R3: If either timer-match bit (`soft_int_i[0]` or `soft_int_i[16]`) is set, level 14 counts as pending.
- R4: While `vec_busy_i` is 1, `irq_req_o` and `irq_tt_o` keep their values at the next edge, whatever the other inputs do.
- R5: If the pending vector, read as an unsigned number, is below `2 << pil_i`, the next edge clears the request and sets the trap type to 0. A pending level equal to `pil_i` therefore does not raise a request.
- R6: With interrupts enabled, the highest set level above `pil_i` is chosen.
- R7: The trap type is 0x40 | level, taken at the edge after the inputs are applied, and `irq_req_o` is 1 while it is nonzero. A new request is latched only when its type differs from the latched one.
- R8: If `trap_lvl_i` is nonzero, `act_tt_i & 0x1F0` equals 0x40, and `act_tt_i` is greater than the new trap type, the outputs keep their values. If any of these three conditions fails, the new type is latched.
- R9: With `int_en_i` at 0 (and no vector busy), the next edge clears the request and sets the trap type to 0.
- R10: With `pil_i` at 15, no level can raise a request, even if all external lines are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl_i | input | 16 | External interrupt level lines, bit n = level n |
| soft_int_i | input | 17 | Software interrupt register; bit 0 tick match, bit 16 system-tick match |
| pil_i | input | 4 | Current priority threshold |
| int_en_i | input | 1 | Global interrupt enable |
| trap_lvl_i | input | 3 | Current trap nesting level |
| act_tt_i | input | 9 | Trap type of the active trap |
| vec_busy_i | input | 1 | Vector interrupt pending |
| irq_req_o | output | 1 | Hard interrupt request |
| irq_tt_o | output | 9 | Selected trap type |

## Verification
Some rules are checked by the assertions on every cycle. These are the hold while a vector is busy, the clear when interrupts are disabled or nothing lies above the threshold, the nesting hold, and the fact that the request and a nonzero group-0x40 trap type always go together. Other behaviours can only be shown by the bench scenarios. These are the choice of the correct level among several pending ones, the folding of the timer flags into level 14, the masking of those flags out of the other levels, and the threshold boundary at the top and bottom of its range.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LVL_CNT  = 16;
  localparam int unsigned LVL_W    = $clog2(LVL_CNT);
  localparam int unsigned TT_W     = 9;
  localparam int unsigned TL_W     = 3;
  localparam int unsigned TMR_LVL  = 14;
  localparam logic [TT_W-1:0] EXT_BASE   = 9'h040;
  localparam logic [TT_W-1:0] GROUP_MASK = 9'h1F0;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int unsigned LVL_CNT = irq_res_pkg::LVL_CNT,
  parameter int unsigned TMR_LVL = irq_res_pkg::TMR_LVL
) (
  input  logic [LVL_CNT-1:0] ext_lvl_i,
  input  logic [LVL_CNT:0]   soft_int_i,
  output logic [LVL_CNT-1:0] pend_o
);
  logic tmr_hit;
  assign tmr_hit = soft_int_i[0] | soft_int_i[LVL_CNT];

  for (genvar g = 0; g < LVL_CNT; g++) begin : g_bit
    if (g == 0) begin : g_lsb
      assign pend_o[g] = ext_lvl_i[g];
    end else if (g == TMR_LVL) begin : g_tmr
      assign pend_o[g] = ext_lvl_i[g] | soft_int_i[g] | tmr_hit;
    end else begin : g_plain
      assign pend_o[g] = ext_lvl_i[g] | soft_int_i[g];
    end
  end
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int unsigned LVL_CNT = irq_res_pkg::LVL_CNT,
  localparam int unsigned LVL_W  = $clog2(LVL_CNT)
) (
  input  logic [LVL_CNT-1:0] pend_i,
  input  logic [LVL_W-1:0]   pil_i,
  output logic               below_o,
  output logic               found_o,
  output logic [LVL_W-1:0]   lvl_o
);
  localparam logic [LVL_CNT:0] TWO = (LVL_CNT+1)'(2);
  logic [LVL_CNT:0] limit;

  always_comb begin
    limit   = TWO << pil_i;
    below_o = ({1'b0, pend_i} < limit);
  end

  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int i = 0; i < int'(LVL_CNT); i++) begin
      if (pend_i[i] && (i > int'(pil_i))) begin
        found_o = 1'b1;
        lvl_o   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int unsigned LVL_W = irq_res_pkg::LVL_W,
  parameter int unsigned TT_W  = irq_res_pkg::TT_W,
  parameter int unsigned TL_W  = irq_res_pkg::TL_W,
  parameter logic [TT_W-1:0] EXT_BASE   = irq_res_pkg::EXT_BASE,
  parameter logic [TT_W-1:0] GROUP_MASK = irq_res_pkg::GROUP_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_busy_i,
  input  logic             int_en_i,
  input  logic             below_i,
  input  logic             found_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [TL_W-1:0]  trap_lvl_i,
  input  logic [TT_W-1:0]  act_tt_i,
  output logic             req_o,
  output logic [TT_W-1:0]  tt_o
);
  logic            req_q, req_d;
  logic [TT_W-1:0] tt_q, tt_d, new_tt;
  logic            nest_block, upd;

  always_comb begin
    new_tt     = EXT_BASE | TT_W'(lvl_i);
    nest_block = (trap_lvl_i != '0) &&
                 ((act_tt_i & GROUP_MASK) == EXT_BASE) &&
                 (act_tt_i > new_tt);
    req_d = req_q;
    tt_d  = tt_q;
    if (!vec_busy_i) begin
      if (below_i || !int_en_i) begin
        req_d = 1'b0;
        tt_d  = '0;
      end else if (found_i && !nest_block && (new_tt != tt_q)) begin
        req_d = 1'b1;
        tt_d  = new_tt;
      end
    end
    upd = (req_d != req_q) || (tt_d != tt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else if (upd) begin
      req_q <= req_d;
      tt_q  <= tt_d;
    end
  end

  assign req_o = req_q;
  assign tt_o  = tt_q;

  // R4: vector busy freezes the outputs
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy_i |=> ($stable(req_o) && $stable(tt_o)));

  // R9: disabled interrupts withdraw the request
  p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy_i && !int_en_i) |=> (!req_o && tt_o == '0));

  // R5: nothing above threshold withdraws the request
  p_below_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy_i && below_i) |=> (!req_o && tt_o == '0));

  // R8: nested higher external trap keeps the latched type
  p_nest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy_i && int_en_i && !below_i && nest_block) |=> $stable(tt_o));

  // R7: a request always carries a group type; R1: idle means zero type
  p_tt_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((tt_o & GROUP_MASK) == EXT_BASE));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (tt_o == '0));
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int unsigned LVL_CNT = irq_res_pkg::LVL_CNT,
  parameter int unsigned TT_W    = irq_res_pkg::TT_W,
  parameter int unsigned TL_W    = irq_res_pkg::TL_W,
  localparam int unsigned LVL_W  = $clog2(LVL_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_CNT-1:0] ext_lvl_i,
  input  logic [LVL_CNT:0]   soft_int_i,
  input  logic [LVL_W-1:0]   pil_i,
  input  logic               int_en_i,
  input  logic [TL_W-1:0]    trap_lvl_i,
  input  logic [TT_W-1:0]    act_tt_i,
  input  logic               vec_busy_i,
  output logic               irq_req_o,
  output logic [TT_W-1:0]    irq_tt_o
);
  logic [LVL_CNT-1:0] pend;
  logic               below, found;
  logic [LVL_W-1:0]   lvl;

  irq_pend_merge #(.LVL_CNT(LVL_CNT), .TMR_LVL(irq_res_pkg::TMR_LVL)) u_merge (
    .ext_lvl_i (ext_lvl_i),
    .soft_int_i(soft_int_i),
    .pend_o    (pend)
  );

  irq_prio_find #(.LVL_CNT(LVL_CNT)) u_find (
    .pend_i (pend),
    .pil_i  (pil_i),
    .below_o(below),
    .found_o(found),
    .lvl_o  (lvl)
  );

  irq_req_ctrl #(.LVL_W(LVL_W), .TT_W(TT_W), .TL_W(TL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_busy_i(vec_busy_i),
    .int_en_i  (int_en_i),
    .below_i   (below),
    .found_i   (found),
    .lvl_i     (lvl),
    .trap_lvl_i(trap_lvl_i),
    .act_tt_i  (act_tt_i),
    .req_o     (irq_req_o),
    .tt_o      (irq_tt_o)
  );
endmodule

// File: tb/test_irq_level_resolver.sv
module test_irq_level_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_lvl = '0;
  logic [16:0] soft_int = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  act_tt = '0;
  logic        vec_busy = 1'b0;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_resolver i_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .ext_lvl_i(ext_lvl), .soft_int_i(soft_int),
    .pil_i(pil), .int_en_i(int_en), .trap_lvl_i(trap_lvl), .act_tt_i(act_tt),
    .vec_busy_i(vec_busy), .irq_req_o(irq_req), .irq_tt_o(irq_tt)
  );

  task automatic drive(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                       input logic en, input logic [2:0] tl, input logic [8:0] at,
                       input logic vb);
    @(negedge clk);
    ext_lvl = e; soft_int = s; pil = p; int_en = en;
    trap_lvl = tl; act_tt = at; vec_busy = vb;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input logic exp_req, input logic [8:0] exp_tt, input string tag);
    checks++;
    if (irq_req !== exp_req || irq_tt !== exp_tt) begin
      errors++;
      $display("FAIL %s: req=%0b tt=0x%0h expected req=%0b tt=0x%0h",
               tag, irq_req, irq_tt, exp_req, exp_tt);
    end
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    chk(1'b0, 9'h000, "R1 reset state");
    @(negedge clk); rst_n = 1'b1;
    drive(16'h0, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R1 idle after reset");
  endtask

  task automatic t_threshold;
    drive(16'h0040, 17'h0, 4'd5, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h046, "R5 R7 level 6 above threshold 5");
    drive(16'h0040, 17'h0, 4'd6, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R5 level equal to threshold clears");
  endtask

  task automatic t_merge;
    drive(16'h0020, 17'h00200, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h049, "R2 R6 soft level 9 over ext level 5");
    drive(16'h1020, 17'h00200, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04C, "R6 ext level 12 highest");
  endtask

  task automatic t_timer;
    drive(16'h0, 17'h0, 4'd3, 1'b0, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R9 disable clears");
    drive(16'h0, 17'h10000, 4'd3, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04E, "R3 system-tick match gives level 14");
    drive(16'h0, 17'h0, 4'd3, 1'b0, 3'd0, 9'h0, 1'b0);
    drive(16'h0, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04E, "R2 R3 tick match gives level 14 not 0");
    drive(16'h0, 17'h10001, 4'd14, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R2 R3 timer flags not above threshold 14");
  endtask

  task automatic t_busy;
    drive(16'h0, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04E, "R3 setup before busy");
    drive(16'h8000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1);
    chk(1'b1, 9'h04E, "R4 busy holds against higher level");
    drive(16'h0, 17'h0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b1);
    chk(1'b1, 9'h04E, "R4 busy holds against disable");
    drive(16'h8000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04F, "R4 release resumes evaluation");
  endtask

  task automatic t_nested;
    drive(16'h0008, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h043, "R7 level 3");
    drive(16'h0004, 17'h0, 4'd0, 1'b1, 3'd1, 9'h04F, 1'b0);
    chk(1'b1, 9'h043, "R8 nested higher ext trap holds");
    drive(16'h0004, 17'h0, 4'd0, 1'b1, 3'd1, 9'h020, 1'b0);
    chk(1'b1, 9'h042, "R8 active trap outside group updates");
    drive(16'h0020, 17'h0, 4'd0, 1'b1, 3'd1, 9'h041, 1'b0);
    chk(1'b1, 9'h045, "R8 active type lower updates");
    drive(16'h0002, 17'h0, 4'd0, 1'b1, 3'd0, 9'h04F, 1'b0);
    chk(1'b1, 9'h041, "R8 trap level zero updates");
  endtask

  task automatic t_top_thr;
    drive(16'hFFFF, 17'h1FFFF, 4'd15, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R10 threshold 15 blocks all");
    drive(16'hFFFF, 17'h0, 4'd14, 1'b1, 3'd0, 9'h0, 1'b0);
    chk(1'b1, 9'h04F, "R10 threshold 14 admits level 15");
    drive(16'hFFFF, 17'h0, 4'd14, 1'b0, 3'd0, 9'h0, 1'b0);
    chk(1'b0, 9'h000, "R9 disable withdraws request");
  endtask

  initial begin
    t_reset();
    t_threshold();
    t_merge();
    t_timer();
    t_busy();
    t_nested();
    t_top_thr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule